// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block sends one management frame to a PHY over a two-wire management bus. Software writes a complete 32-bit frame word into the data register. The word holds the start code, the opcode, the PHY address, the register address, the turnaround pattern and the data field. The controller then drives 32 preamble ones and after them the frame word, most significant bit first, on the data pin. It produces the management clock from the system clock. Each half period lasts a programmable number of system clocks.

On a read frame the controller releases the data pin for the second turnaround bit and for the sixteen data bits. It samples the PHY's reply on each rising management-clock edge and stores it in the low half of the data register. When the last bit ends, a sticky done flag is set. Software clears the flag by writing a one to it.

The controller has three states. In `ST_IDLE` the clock is low and the pin is released. In `ST_LOW` the clock is low and the pin changes. In `ST_HIGH` the clock is high and the pin is sampled. The transitions are:
- start: `ST_IDLE` to `ST_LOW`.
- rise: `ST_LOW` to `ST_HIGH`, after N clocks.
- fall: `ST_HIGH` to `ST_LOW`, after N clocks, for a bit that is not the last.
- finish: `ST_HIGH` to `ST_IDLE`, after the last bit.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: A write to address 0 (data) starts a frame only when the enable bit (address 3, bit 0) is set and the controller is idle. Busy reads back at address 3, bit 1.
- R2: A frame is 64 bit periods: first 32 ones, then data register bits 31 down to 0.
- R3: The management clock is low for N system clocks and then high for N system clocks in every bit. N is the speed field. The data pin changes only while the clock is low.
- R4: On a read frame (bits 29:28 = 10), output enable is low from frame bit 16 through frame bit 0. In every other bit of a busy period it is high. Output enable is low whenever the controller is idle.
- R5: On a read frame, frame bits 15:0 are sampled at the rising clock edges into data register bits 15:0. Bits 31:16 keep the value that was written.
- R6: The end of a frame sets the done flag (address 1, bit 0). Writing 1 to it clears it. Writing 0 leaves it set.
- R7: The speed field is bits 6:1 of address 2. Other bits are ignored and read back as zero. A speed of 0 halts the clock until a nonzero value is written.
- R8: A write to the data register while busy is ignored. The frame and the register contents are unchanged.
- R9: While enable is clear, a data write starts no frame.
- R10: After reset the clock is low, output enable is low, the data pin is 1, busy is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 2 | register select (0 data, 1 event, 2 speed, 3 control) |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from reg_addr |
| mdc | output | 1 | management clock |
| mdio_o | output | 1 | data pin output value |
| mdio_oe | output | 1 | data pin output enable |
| mdio_i | input | 1 | data pin input value |

## Verification
A register write takes effect on the clock edge where it is presented. The pins reflect the new state in the same cycle that follows that edge. A bit period lasts 2N cycles, and a frame ends exactly 128N cycles after the starting edge; the done flag and the idle state appear in the cycle after that. The bench's model counts cycles from each start with integers and derives the expected pin values from that count. It compares them at every falling system-clock edge, so each result is checked in the cycle it is due. Register readbacks are taken at the same falling edge once the model reports the frame complete.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } mdio_state_t;

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_EVENT = 2'd1;
    localparam logic [1:0] ADDR_SPEED = 2'd2;
    localparam logic [1:0] ADDR_CTRL  = 2'd3;

    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int DW      = 32,
    parameter int PRE     = 32,
    parameter int DIVW    = 6,
    parameter int REL_POS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] speed,
    input  logic            enable,
    input  logic            start_wr,
    input  logic [DW-1:0]   wdata,
    input  logic            mdio_i,
    output logic            mdc,
    output logic            mdio_o,
    output logic            mdio_oe,
    output logic            busy,
    output logic            frame_done,
    output logic [DW-1:0]   data_q
);
    localparam int TOTAL = PRE + DW;
    localparam int IW    = $clog2(TOTAL + 1);
    localparam int PW    = $clog2(DW);

    mdio_state_t     state_q, state_d;
    logic [DIVW-1:0] cnt_q;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   rel;
    logic [PW-1:0]   pos;
    logic            in_frame, is_read, last_bit, phase_end, start_ok;

    assign rel       = idx_q - IW'(PRE);
    assign pos       = PW'(DW - 1) - rel[PW-1:0];
    assign in_frame  = idx_q >= IW'(PRE);
    assign is_read   = data_q[DW-3:DW-4] == OP_READ;
    assign last_bit  = idx_q == IW'(TOTAL - 1);
    assign phase_end = (speed != '0) &&
                       ({1'b0, cnt_q} + 1'b1 >= {1'b0, speed});
    assign start_ok  = start_wr && enable && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok)  state_d = ST_LOW;
            ST_LOW:  if (phase_end) state_d = ST_HIGH;
            ST_HIGH: if (phase_end) state_d = last_bit ? ST_IDLE : ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start_ok) begin
                        idx_q  <= '0;
                        data_q <= wdata;
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        cnt_q <= '0;
                        if (is_read && in_frame && (32'(pos) < REL_POS))
                            data_q[pos] <= mdio_i;
                    end else if (speed != '0) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        cnt_q <= '0;
                        if (!last_bit) idx_q <= idx_q + 1'b1;
                    end else if (speed != '0) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        mdc        = state_q == ST_HIGH;
        busy       = state_q != ST_IDLE;
        frame_done = (state_q == ST_HIGH) && phase_end && last_bit;
        mdio_oe    = busy && !(is_read && in_frame && (32'(pos) <= REL_POS));
        mdio_o     = (!busy || !in_frame) ? 1'b1 : data_q[pos];
    end

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o)); // R3
    AST_HALT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && speed == '0) |=> $stable(mdc)); // R7
    AST_IGNORE_BUSY_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_wr && !is_read) |=> $stable(data_q)); // R8
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !busy); // R9
    AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc)); // R4
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter int DW   = 32,
    parameter int DIVW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic [DW-1:0]   data_q,
    input  logic            busy,
    input  logic            frame_done,
    output logic [DIVW-1:0] speed,
    output logic            enable,
    output logic            done,
    output logic [DW-1:0]   reg_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed  <= '0;
            enable <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_SPEED) speed  <= reg_wdata[DIVW:1];
            if (reg_wr && reg_addr == ADDR_CTRL)  enable <= reg_wdata[0];
            if (frame_done)
                done <= 1'b1;
            else if (reg_wr && reg_addr == ADDR_EVENT && reg_wdata[0])
                done <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_DATA:  reg_rdata = data_q;
            ADDR_EVENT: reg_rdata = DW'(done);
            ADDR_SPEED: reg_rdata = DW'(speed) << 1;
            default:    reg_rdata = DW'({busy, enable});
        endcase
    end

    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> done); // R6
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int DW   = 32,
    parameter int PRE  = 32,
    parameter int DIVW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);
    logic [DIVW-1:0] speed;
    logic            enable, busy, frame_done, done;
    logic [DW-1:0]   data_q;

    mdio_regfile #(.DW(DW), .DIVW(DIVW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .data_q     (data_q),
        .busy       (busy),
        .frame_done (frame_done),
        .speed      (speed),
        .enable     (enable),
        .done       (done),
        .reg_rdata  (reg_rdata)
    );

    mdio_frame_engine #(.DW(DW), .PRE(PRE), .DIVW(DIVW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed      (speed),
        .enable     (enable),
        .start_wr   (reg_wr && reg_addr == ADDR_DATA),
        .wdata      (reg_wdata),
        .mdio_i     (mdio_i),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .busy       (busy),
        .frame_done (frame_done),
        .data_q     (data_q)
    );

    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy); // R6
endmodule

// File: tb/mdio_frame_ctrl_bench.sv
module mdio_frame_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural reference model state
    bit          m_active = 0;
    bit          m_done = 0;
    bit          m_en = 0;
    int          m_n = 0;
    int          m_t = 0;
    logic [31:0] m_word = '0;
    logic [15:0] resp = 16'h3C5A;

    always #4 clk = ~clk;

    mdio_frame_ctrl u_mdio_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit was_active;
        int b;
        cycles++;
        if (!rst_n) begin
            m_active = 0; m_done = 0; m_en = 0; m_n = 0; m_t = 0; m_word = '0;
        end else begin
            was_active = m_active;
            if (reg_wr && reg_addr == 2'd1 && reg_wdata[0]) m_done = 0;
            if (m_active && m_n != 0) begin
                b = m_t / (2 * m_n);
                if ((m_t % (2 * m_n)) == m_n - 1 && b >= 48 && m_word[29:28] == 2'b10)
                    m_word[63 - b] = mdio_i;
                m_t++;
                if (m_t == 128 * m_n) begin
                    m_active = 0;
                    m_done = 1;
                end
            end
            if (!was_active && reg_wr && reg_addr == 2'd0 && m_en) begin
                m_active = 1; m_t = 0; m_word = reg_wdata;
            end
            if (reg_wr && reg_addr == 2'd2) m_n = int'(reg_wdata[6:1]);
            if (reg_wr && reg_addr == 2'd3) m_en = reg_wdata[0];
        end
    end

    // PHY reply and per-cycle pin comparison
    always @(negedge clk) begin
        int b;
        bit hi, rd;
        logic exp_o;
        if (rst_n) begin
            b = 0; hi = 0;
            if (m_active && m_n != 0) begin
                b = m_t / (2 * m_n);
                hi = (m_t % (2 * m_n)) >= m_n;
            end
            rd = m_word[29:28] == 2'b10;
            exp_o = (!m_active || b < 32) ? 1'b1 : m_word[63 - b];
            chk("R3 mdc", 32'(mdc), 32'(m_active && hi));
            chk("R2 mdio_o", 32'(mdio_o), 32'(exp_o));
            chk("R4 mdio_oe", 32'(mdio_oe), 32'(m_active && !(rd && b >= 47)));
            mdio_i = (m_active && b >= 48) ? resp[63 - b] : 1'b0;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        while (m_active) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, wframe, rframe;
        wframe = (32'd1 << 30) | (32'd1 << 28) | (32'd5 << 23) | (32'd3 << 18) | (32'd2 << 16) | 32'hA5C3;
        rframe = (32'd1 << 30) | (32'd2 << 28) | (32'd1 << 23) | (32'd2 << 18) | 32'h0000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 mdc", 32'(mdc), 0);
        chk("R10 oe", 32'(mdio_oe), 0);
        chk("R10 mdio_o", 32'(mdio_o), 1);
        rd(2'd3, v); chk("R10 busy/enable", v, 0);
        rd(2'd1, v); chk("R10 done", v, 0);
        // R7 speed field placement
        wr(2'd2, 32'hFFFF_FF85);
        rd(2'd2, v); chk("R7 speed readback", v, 32'h4);
        // R9 enable clear blocks start
        wr(2'd0, wframe);
        repeat (5) @(negedge clk);
        rd(2'd3, v); chk("R9 no start when disabled", v, 0);
        // R1 start and busy
        wr(2'd3, 32'h1);
        wr(2'd0, wframe);
        rd(2'd3, v); chk("R1 busy set", v, 32'h3);
        repeat (10) @(negedge clk);
        wr(2'd0, 32'hFFFF_FFFF); // R8 ignored while busy
        wait_idle();
        rd(2'd0, v); chk("R8 data unchanged", v, wframe);
        rd(2'd1, v); chk("R6 done set", v, 1);
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk("R6 zero write keeps done", v, 1);
        wr(2'd1, 32'h1);
        rd(2'd1, v); chk("R6 cleared", v, 0);
        // R5 read frame at N=3
        wr(2'd2, 32'h6);
        wr(2'd0, rframe);
        wait_idle();
        rd(2'd0, v); chk("R5 read data", v, {rframe[31:16], resp});
        // R7 halt with speed zero
        wr(2'd1, 32'h1);
        wr(2'd2, 32'h0);
        resp = 16'h8001;
        wr(2'd0, rframe);
        repeat (40) @(negedge clk);
        rd(2'd3, v); chk("R7 halted but busy", v, 32'h3);
        chk("R7 mdc held low", 32'(mdc), 0);
        wr(2'd2, 32'h2);
        wait_idle();
        rd(2'd0, v); chk("R7 resumed read data", v, {rframe[31:16], resp});
        rd(2'd1, v); chk("R6 done after resume", v, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule